// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This unit operates on a contiguous run of bits inside a 32-bit word. The run is named by the index of its highest bit and by its length in bits. In extract mode the unit returns that run moved down to bit 0, with every bit above it cleared. In insert mode it takes the low bits of a source word and writes them over the run inside a destination word. All destination bits outside the run are kept.

Extraction is built from two shifts. A left shift by (31 − top index) puts the run's top bit at bit 31. A logical right shift by (32 − length) then brings the run down to bit 0. Insertion first trims the source to the run length and shifts it up to the run's lowest bit. It then clears the run in the destination with an AND-NOT mask and ORs the shifted source in.

A request whose length does not fit below its top index is refused. In that case an error flag is raised and the destination word is passed through unchanged. Every result is registered once, so it appears one clock after the request.

Top module: `bfx_unit`

## Requirements
- R1: `res_o` and `bad_o` reflect the request presented at a rising clock edge from that edge until the next one, so there is one cycle of latency. While `rst_n` is low both outputs read zero.
- R2: With `op_i` = 0 (extract), `res_o` holds bits `top_i` down to `top_i − len_i + 1` of `dst_i` at bit positions `len_i − 1` to 0, and every higher bit of `res_o` is zero.
- R3: An extract with `len_i` = 32 and `top_i` = 31 returns `dst_i` unchanged, and an extract of length 1 returns the single bit at `top_i`.
- R4: With `op_i` = 1 (insert), bits `top_i` down to `top_i − len_i + 1` of `res_o` equal bits `len_i − 1` down to 0 of `src_i`.
- R5: On an insert, every bit of `res_o` outside the field equals the matching bit of `dst_i`. Bits of `src_i` at or above position `len_i` have no effect on `res_o`.
- R6: `bad_o` is 1 exactly when `len_i` is 0, `len_i` is greater than 32, or `top_i` + 1 < `len_i`.
- R7: When `bad_o` is 1, `res_o` equals `dst_i` for either value of `op_i`.
- R8: Extracting a byte from 0x12345678 gives 0x56 for bits 15..8 and 0x78 for bits 7..0. Inserting 0xFF over bits 9..2 of zero gives 0x3FC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 1 | 0 selects extract, 1 selects insert |
| dst_i | input | 32 | Word to read the field from, or to write it into |
| src_i | input | 32 | Field value for insert, taken from its low bits |
| top_i | input | 5 | Index of the field's highest bit |
| len_i | input | 6 | Field length in bits, 1 to 32 |
| res_o | output | 32 | Registered result |
| bad_o | output | 1 | Registered flag for an invalid field |

## Verification
Two of the unit's functions meet in the same cycle when an insert carries source bits above the field while the field also reaches the word's upper or lower edge. In that case the masking of the source and the keeping of the destination outside the field must both hold on one result. The bench provokes this with all-ones sources and 0xA5A5A5A5-style destinations at fields touching bit 0 and bit 31, and at fields sitting alone in the middle. The error check and the data path also meet when an invalid length arrives with insert mode. The bench judges every such case against a bit-by-bit reference model and expects the destination passed through.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
    parameter int DATA_W = 32;
    localparam int IDX_W = $clog2(DATA_W);
    localparam int LEN_W = IDX_W + 1;

    typedef enum logic {
        OP_EXTRACT = 1'b0,
        OP_INSERT  = 1'b1
    } bfx_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              bad;
    } bfx_state_t;
endpackage

// File: rtl/bfx_range_check.sv
module bfx_range_check
    import bfx_pkg::*;
(
    input  logic [IDX_W-1:0] top_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             bad_o,
    output logic [IDX_W-1:0] low_o
);
    logic [LEN_W:0] top_plus;
    logic [LEN_W:0] len_ext;

    always_comb begin
        top_plus = {{(LEN_W+1-IDX_W){1'b0}}, top_i} + 1'b1;
        len_ext  = {1'b0, len_i};
        bad_o    = (len_i == '0) || (len_ext > (LEN_W+1)'(DATA_W)) || (top_plus < len_ext);
        low_o    = IDX_W'(top_plus - len_ext);
    end
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract
    import bfx_pkg::*;
(
    input  logic [DATA_W-1:0] word_i,
    input  logic [IDX_W-1:0]  top_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [DATA_W-1:0] field_o
);
    logic [LEN_W-1:0]  up_amt;
    logic [LEN_W-1:0]  down_amt;
    logic [DATA_W-1:0] raised;

    always_comb begin
        up_amt   = LEN_W'(DATA_W - 1) - {1'b0, top_i};
        down_amt = LEN_W'(DATA_W) - len_i;
        raised   = word_i << up_amt;
        field_o  = raised >> down_amt;
    end
endmodule

// File: rtl/bfx_insert.sv
module bfx_insert
    import bfx_pkg::*;
(
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [IDX_W-1:0]  low_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] len_mask;
    logic [DATA_W-1:0] hole;
    logic [DATA_W-1:0] placed;

    always_comb begin
        if (len_i >= LEN_W'(DATA_W))
            len_mask = '1;
        else
            len_mask = (DATA_W'(1) << len_i) - DATA_W'(1);
        hole   = len_mask << low_i;
        placed = (src_i & len_mask) << low_i;
        word_o = (dst_i & ~hole) | placed;
    end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [IDX_W-1:0]  top_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [DATA_W-1:0] res_o,
    output logic              bad_o
);
    bfx_state_t        st_d, st_q;
    logic              range_bad;
    logic [IDX_W-1:0]  low_idx;
    logic [DATA_W-1:0] ext_word;
    logic [DATA_W-1:0] ins_word;

    bfx_range_check u_range (
        .top_i (top_i),
        .len_i (len_i),
        .bad_o (range_bad),
        .low_o (low_idx)
    );

    bfx_extract u_ext (
        .word_i  (dst_i),
        .top_i   (top_i),
        .len_i   (len_i),
        .field_o (ext_word)
    );

    bfx_insert u_ins (
        .dst_i  (dst_i),
        .src_i  (src_i),
        .low_i  (low_idx),
        .len_i  (len_i),
        .word_o (ins_word)
    );

    always_comb begin
        st_d.bad = range_bad;
        if (range_bad)
            st_d.res = dst_i;
        else if (bfx_op_e'(op_i) == OP_INSERT)
            st_d.res = ins_word;
        else
            st_d.res = ext_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign res_o = st_q.res;
    assign bad_o = st_q.bad;

    // Assertions beside the datapath they guard
    assert_err_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_o == ($past(len_i) == 0 || $past(len_i) > DATA_W ||
                  (32'($past(top_i)) + 1) < 32'($past(len_i))));

    assert_err_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_o |-> res_o == $past(dst_i));

    assert_extract_zero_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bad_o && $past(op_i) == 1'b0) |-> (64'(res_o) >> $past(len_i)) == 64'd0);

    assert_insert_keep_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bad_o && $past(op_i) == 1'b1) |->
        ((64'(res_o ^ $past(dst_i))) >> (32'($past(top_i)) + 1)) == 64'd0);

    assert_insert_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bad_o && $past(op_i) == 1'b1) |->
        ((64'(res_o) >> (32'($past(top_i)) + 1 - 32'($past(len_i)))) << (64 - 32'($past(len_i))))
        == (64'($past(src_i)) << (64 - 32'($past(len_i)))));
endmodule

// File: tb/tb_bfx_unit.sv
module tb_bfx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_i = 1'b0;
    logic [31:0] dst_i = '0;
    logic [31:0] src_i = '0;
    logic [4:0]  top_i = '0;
    logic [5:0]  len_i = 6'd1;
    logic [31:0] res_o;
    logic        bad_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] res;
        logic        bad;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    bfx_unit dut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(string tag, logic op, logic [31:0] d, logic [31:0] s,
                         int top, int len);
        exp_t e;
        int lo;
        @(negedge clk);
        op_i = op; dst_i = d; src_i = s; top_i = 5'(top); len_i = 6'(len);
        e.tag = tag;
        e.bad = (len == 0) || (len > 32) || (top + 1 < len);
        if (e.bad) e.res = d;
        else begin
            lo = top + 1 - len;
            if (op) begin
                e.res = d;
                for (int i = 0; i < len; i++) e.res[lo+i] = s[i];
            end else begin
                e.res = '0;
                for (int i = 0; i < len; i++) e.res[i] = d[lo+i];
            end
        end
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " res"}, res_o, e.res);
            check({e.tag, " bad"}, {31'd0, bad_o}, {31'd0, e.bad});
        end
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #35;
        check("R1 reset res", res_o, 32'h0);
        check("R1 reset bad", {31'd0, bad_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        drive("R8 byte1",        0, 32'h12345678, 0, 15, 8);
        drive("R8 byte0",        0, 32'h12345678, 0, 7, 8);
        drive("R2 mid field",    0, 32'hB6A43D9A, 0, 9, 8);
        drive("R2 odd field",    0, 32'hDEADBEEF, 0, 20, 5);
        drive("R3 full word",    0, 32'h92345678, 0, 31, 32);
        drive("R3 one bit hi",   0, 32'h80000000, 0, 31, 1);
        drive("R3 one bit lo",   0, 32'h00000001, 0, 0, 1);
        drive("R8 insert 3FC",   1, 32'h0, 32'hFF, 9, 8);
        drive("R4 insert mid",   1, 32'hA5A5A5A5, 32'h3C, 9, 8);
        drive("R5 src high ign", 1, 32'hA5A5A5A5, 32'hFFFFFFFF, 20, 4);
        drive("R5 field at lsb", 1, 32'h5A5A5A5A, 32'hFFFFFF00, 7, 8);
        drive("R5 field at msb", 1, 32'h5A5A5A5A, 32'h00000123, 31, 3);
        drive("R4 insert whole", 1, 32'h11111111, 32'hCAFEF00D, 31, 32);
        drive("R6 len zero",     0, 32'h0BADF00D, 0, 10, 0);
        drive("R6 len too big",  1, 32'h0BADF00D, 32'hFFFFFFFF, 31, 40);
        drive("R7 top too low",  1, 32'h76543210, 32'hFFFFFFFF, 3, 5);
        drive("R7 extract bad",  0, 32'h76543210, 0, 6, 8);
        drive("R6 edge ok",      0, 32'hF0F0F0F0, 0, 7, 8);
        for (int k = 0; k < 32; k++)
            drive("R2 sweep", 0, 32'hC3A5_9E71 ^ (32'(k) * 32'h01010101), 0, k, (k % 5) + 1);
        for (int k = 0; k < 32; k++)
            drive("R5 sweep", 1, 32'h6B2D_E419, 32'hFFFF_FFFF ^ 32'(k), 31 - k, (k % 7) + 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R1 reset again", res_o, 32'h0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule